// File: doc/BRIEF.md
# Memory Controller Self-Test Sequencer

This block drives the user-side request port of an SDRAM controller with a fixed series of tests and checks every word that comes back. The tests run in a fixed order once reset is released: a sequential sweep, a short-burst write pass, a byte-mask pass, an address-line walk and two low-power holds. Each read beat is compared lane by lane against a value the block recomputes from the read's address and the running test. Because of this, no copy of the written data is stored.

Four results are visible at the outputs. A sticky pass flag falls on the first bad beat. A per-lane pass vector follows the most recent beat. A one-hot status vector names the running test. A one-cycle completion pulse marks the end of the run. Requests are held until the controller's ready is high. Read returns are counted, and no test starts while a read is still outstanding.

The controller is in one of seven states:
- S_PICK skips any disabled test and enters S_WR or S_HOLD. It goes to S_FIN when no test is left.
- S_WR issues writes. It moves to S_RD after the last write, or after every write in the address-line test.
- S_RD issues reads. It goes back to S_WR in the address-line test, and to S_DRAIN after the last read.
- S_DRAIN waits for outstanding reads to reach zero, then returns to S_PICK.
- S_HOLD keeps a low-power request raised, then returns to S_PICK.
- S_FIN lasts one cycle and moves to S_DONE.
- S_DONE is terminal.

Top module: `memtest_sequencer`

## Requirements
- R1: `pass` is 1 after reset. It falls in the cycle after the first read beat whose data differs from the expected value, and it stays 0 until reset.
- R2: Bit i of `pass_byte` covers bits [8i+7:8i] of the data. It is 1 after reset. In the cycle after each `rd_valid` beat it shows whether that lane matched. It does not change in any cycle that follows a cycle without `rd_valid`.
- R3: `status` is one-hot for the running test and 0 in every other cycle. Bit 0 is the sequential test, bit 1 short-write, bit 2 byte-mask, bit 3 address-line, bit 4 power-down and bit 5 self-refresh. Bit 6 (auto-precharge) stays 0.
- R4: `complete` is high for exactly one cycle, after every enabled test has ended and every read has returned. After it, no request of any kind is issued.
- R5: A write or read request is never raised together with the other. Address, data and byte enables stay stable until a cycle with `ready` high, which transfers the request.
- R6: Let P(a) = ((a*40503) mod 2^16) XOR 0x5AC3. The sequential test writes P(a) to addresses 0 to SEQ_WORDS-1 in ascending order, with all byte enables and `burst` = MAX_BURST. It then reads the same addresses in the same order and expects P(a).
- R7: When `en_short` is 1 and MAX_BURST is 2, the short-write test writes NOT P(a) with `burst` = 1 over the same range. It then reads the range back with `burst` = 1.
- R8: When `en_mask` is 1, the byte-mask test first writes 0 with all enables over the range. It then writes all ones with `byte_en` = 1 (lane 0 only), and finally reads the range expecting 0x00FF.
- R9: When `en_apin` is 1, the address-line test issues a write followed at once by a read of the same address. The addresses come in this order: all zeros, a single 1 walked from bit 0 up, a single 0 walked from bit 0 up, then all zeros. The data is P(a) XOR 0x3C3C.
- R10: When LOWPOWER is nonzero, `pd_req` and then `sr_req` are each raised for max(H,1) consecutive cycles, where H is `hold_cycles`. No request is issued while either is high, and the two are never high together.
- R11: A test whose enable input is 0 issues no request and never sets its status bit. The remaining tests keep their order.
- R12: The first request of a test is issued only after every read of the previous test has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_short | input | 1 | Enables the short-write test |
| en_mask | input | 1 | Enables the byte-mask test |
| en_apin | input | 1 | Enables the address-line test |
| hold_cycles | input | CW | Low-power hold length |
| ready | input | 1 | Controller accepts the current request |
| rd_valid | input | 1 | Read beat valid |
| rd_data | input | DW | Read beat data |
| wr_req | output | 1 | Write request |
| rd_req | output | 1 | Read request |
| addr | output | AW | Request word address |
| wr_data | output | DW | Write data |
| byte_en | output | DW/8 | Write byte enables |
| burst | output | BW | Declared burst length |
| pd_req | output | 1 | Power-down request |
| sr_req | output | 1 | Self-refresh request |
| pass | output | 1 | Sticky pass flag |
| pass_byte | output | DW/8 | Per-lane pass of the last beat |
| status | output | 7 | One-hot running test |
| complete | output | 1 | End-of-run pulse |

## Verification
The case that matters most is a read return landing in the same cycle as a new request is handed off. In that cycle the return-side address regenerator and the issue-side index advance together. This happens all the time in the address-line test, where a write and a read alternate while earlier reads trickle back. The bench provokes it with a ready pattern that has gaps and a read latency that varies between one and three cycles. Every handed-off request is compared with the bench's expected order. The pass flags are compared on every clock with a model that grades each delivered beat against the requirement's pattern, and deliberately corrupted beats in two lanes confirm that the sticky flag latches while the lane flags recover.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
    typedef enum logic [2:0] {
        T_SEQ   = 3'd0,
        T_SHORT = 3'd1,
        T_MASK  = 3'd2,
        T_APIN  = 3'd3,
        T_PDN   = 3'd4,
        T_SREF  = 3'd5,
        T_AUTO  = 3'd6,
        T_END   = 3'd7
    } test_e;

    typedef enum logic [2:0] {
        S_PICK, S_WR, S_RD, S_DRAIN, S_HOLD, S_FIN, S_DONE
    } state_e;

    localparam int STATUS_W = 7;
endpackage

// File: rtl/mts_addrgen.sv
module mts_addrgen
    import memtest_pkg::*;
#(
    parameter int AW = 6,
    parameter int IW = 5
) (
    input  test_e           test,
    input  logic [IW-1:0]   idx,
    output logic [AW-1:0]   addr
);
    // Address-line walk: zeros, walking one, walking zero, zeros
    always_comb begin
        addr = AW'(idx);
        if (test == T_APIN) begin
            if (idx == '0 || int'(idx) > 2 * AW)
                addr = '0;
            else if (int'(idx) <= AW)
                addr = AW'(1) << (idx - IW'(1));
            else
                addr = ~(AW'(1) << (idx - IW'(AW + 1)));
        end
    end
endmodule

// File: rtl/mts_pattern.sv
module mts_pattern
    import memtest_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  test_e           test,
    input  logic            second,
    input  logic            readback,
    input  logic [AW-1:0]   addr,
    output logic [DW-1:0]   data
);
    localparam int NLANE = DW / 8;
    localparam logic [DW-1:0] LANE0 = DW'(8'hFF);

    logic [DW-1:0] base;
    assign base = (DW'(addr) * DW'(40503)) ^ DW'(16'h5AC3);

    always_comb begin
        case (test)
            T_SEQ:   data = base;
            T_SHORT: data = ~base;
            T_MASK:  data = readback ? LANE0 : (second ? '1 : '0);
            T_APIN:  data = base ^ {NLANE{8'h3C}};
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/mts_lanecmp.sv
module mts_lanecmp #(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DW-1:0]     got,
    input  logic [DW-1:0]     want,
    output logic              pass,
    output logic [DW/8-1:0]   pass_byte
);
    localparam int NLANE = DW / 8;
    logic [NLANE-1:0] bad;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign bad[i] = got[i*8 +: 8] != want[i*8 +: 8];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pass_byte[i] <= 1'b1;
            else if (valid) pass_byte[i] <= ~bad[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pass <= 1'b1;
        else if (valid && |bad)    pass <= 1'b0;
    end
endmodule

// File: rtl/mts_rdtrack.sv
module mts_rdtrack #(
    parameter int IW = 5,
    parameter int OW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic            ret,
    input  logic            clear,
    output logic            idle,
    output logic [IW-1:0]   ret_idx
);
    logic [OW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + OW'(issue) - OW'(ret);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ret_idx <= '0;
        else if (clear) ret_idx <= '0;
        else if (ret)   ret_idx <= ret_idx + IW'(1);
    end

    assign idle = cnt == '0;
endmodule

// File: rtl/memtest_sequencer.sv
module memtest_sequencer
    import memtest_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 16,
    parameter int SEQ_WORDS = 16,
    parameter int MAX_BURST = 2,
    parameter int BW        = 2,
    parameter int CW        = 8,
    parameter int LOWPOWER  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_short,
    input  logic                 en_mask,
    input  logic                 en_apin,
    input  logic [CW-1:0]        hold_cycles,
    input  logic                 ready,
    input  logic                 rd_valid,
    input  logic [DW-1:0]        rd_data,
    output logic                 wr_req,
    output logic                 rd_req,
    output logic [AW-1:0]        addr,
    output logic [DW-1:0]        wr_data,
    output logic [DW/8-1:0]      byte_en,
    output logic [BW-1:0]        burst,
    output logic                 pd_req,
    output logic                 sr_req,
    output logic                 pass,
    output logic [DW/8-1:0]      pass_byte,
    output logic [STATUS_W-1:0]  status,
    output logic                 complete
);
    localparam int NLANE      = DW / 8;
    localparam int APIN_ITEMS = 2 * AW + 2;
    localparam int MAXI       = (SEQ_WORDS > APIN_ITEMS) ? SEQ_WORDS : APIN_ITEMS;
    localparam int IW         = $clog2(MAXI) + 1;
    localparam int OW         = IW + 1;
    localparam logic [IW-1:0] SEQ_LAST  = IW'(SEQ_WORDS - 1);
    localparam logic [IW-1:0] APIN_LAST = IW'(APIN_ITEMS - 1);

    state_e         state;
    test_e          test;
    logic [IW-1:0]  idx;
    logic           second;
    logic [CW-1:0]  hold_q, hcnt;
    logic           short_ok, lp_ok, test_on, at_last, drained;
    logic [IW-1:0]  ret_idx;
    logic [AW-1:0]  exp_addr;
    logic [DW-1:0]  exp_data;

    if (MAX_BURST == 2) begin : g_short
        assign short_ok = en_short;
    end else begin : g_noshort
        assign short_ok = 1'b0;
    end

    if (LOWPOWER != 0) begin : g_lp
        assign lp_ok = 1'b1;
    end else begin : g_nolp
        assign lp_ok = 1'b0;
    end

    always_comb begin
        case (test)
            T_SEQ:         test_on = 1'b1;
            T_SHORT:       test_on = short_ok;
            T_MASK:        test_on = en_mask;
            T_APIN:        test_on = en_apin;
            T_PDN, T_SREF: test_on = lp_ok;
            default:       test_on = 1'b0;
        endcase
    end

    assign at_last = idx == ((test == T_APIN) ? APIN_LAST : SEQ_LAST);

    // State register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_PICK;
            test   <= T_SEQ;
            idx    <= '0;
            second <= 1'b0;
            hold_q <= CW'(1);
            hcnt   <= CW'(1);
        end else begin
            unique case (state)
                S_PICK: begin
                    if (test == T_AUTO || test == T_END) begin
                        state <= S_FIN;
                    end else if (test_on) begin
                        idx    <= '0;
                        second <= 1'b0;
                        hcnt   <= CW'(1);
                        hold_q <= (hold_cycles == '0) ? CW'(1) : hold_cycles;
                        state  <= (test == T_PDN || test == T_SREF) ? S_HOLD : S_WR;
                    end else begin
                        test <= test_e'(test + 3'd1);
                    end
                end
                S_WR: if (ready) begin
                    if (test == T_APIN) begin
                        state <= S_RD;
                    end else if (at_last) begin
                        idx <= '0;
                        if (test == T_MASK && !second) second <= 1'b1;
                        else                           state  <= S_RD;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                S_RD: if (ready) begin
                    if (at_last) begin
                        state <= S_DRAIN;
                    end else begin
                        idx <= idx + IW'(1);
                        if (test == T_APIN) state <= S_WR;
                    end
                end
                S_DRAIN: if (drained) begin
                    test  <= test_e'(test + 3'd1);
                    state <= S_PICK;
                end
                S_HOLD: begin
                    if (hcnt == hold_q) begin
                        test  <= test_e'(test + 3'd1);
                        state <= S_PICK;
                    end else begin
                        hcnt <= hcnt + CW'(1);
                    end
                end
                S_FIN:   state <= S_DONE;
                S_DONE:  state <= S_DONE;
                default: state <= S_DONE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        wr_req   = state == S_WR;
        rd_req   = state == S_RD;
        burst    = (test == T_SHORT) ? BW'(1) : BW'(MAX_BURST);
        byte_en  = (wr_req && test == T_MASK && second) ? NLANE'(1) : '1;
        pd_req   = state == S_HOLD && test == T_PDN;
        sr_req   = state == S_HOLD && test == T_SREF;
        complete = state == S_FIN;
        status   = (state == S_WR || state == S_RD || state == S_DRAIN || state == S_HOLD)
                   ? (STATUS_W'(1) << test) : '0;
    end

    mts_addrgen #(.AW(AW), .IW(IW)) u_issue_addr (
        .test(test), .idx(idx), .addr(addr)
    );

    mts_pattern #(.AW(AW), .DW(DW)) u_issue_pat (
        .test(test), .second(second), .readback(1'b0), .addr(addr), .data(wr_data)
    );

    mts_addrgen #(.AW(AW), .IW(IW)) u_ret_addr (
        .test(test), .idx(ret_idx), .addr(exp_addr)
    );

    mts_pattern #(.AW(AW), .DW(DW)) u_ret_pat (
        .test(test), .second(second), .readback(1'b1), .addr(exp_addr), .data(exp_data)
    );

    mts_rdtrack #(.IW(IW), .OW(OW)) u_track (
        .clk(clk), .rst_n(rst_n), .issue(rd_req && ready), .ret(rd_valid),
        .clear(state == S_PICK), .idle(drained), .ret_idx(ret_idx)
    );

    mts_lanecmp #(.DW(DW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .valid(rd_valid), .got(rd_data), .want(exp_data),
        .pass(pass), .pass_byte(pass_byte)
    );
endmodule

// File: rtl/memtest_sequencer_sva.sv
module memtest_sequencer_sva #(
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int NLANE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rd_valid,
    input logic              wr_req,
    input logic              rd_req,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     wr_data,
    input logic              pass,
    input logic [NLANE-1:0]  pass_byte,
    input logic [6:0]        status,
    input logic              complete,
    input logic              pd_req,
    input logic              sr_req
);
    p_pass_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pass |=> !pass);

    p_lane_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(pass_byte));

    p_status_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status) && !status[6]);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> !complete && !wr_req && !rd_req);

    p_single_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && rd_req));

    p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !ready) |=> wr_req && $stable(addr) && $stable(wr_data));

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ready) |=> rd_req && $stable(addr));

    p_lp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req || sr_req) |-> !wr_req && !rd_req && !(pd_req && sr_req));
endmodule

bind memtest_sequencer memtest_sequencer_sva #(.AW(AW), .DW(DW), .NLANE(DW/8)) u_sva (
    .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
    .wr_req(wr_req), .rd_req(rd_req), .addr(addr), .wr_data(wr_data),
    .pass(pass), .pass_byte(pass_byte), .status(status), .complete(complete),
    .pd_req(pd_req), .sr_req(sr_req)
);

// File: tb/sim_memtest_sequencer.sv
`timescale 1ns/1ps
module sim_memtest_sequencer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_short, en_mask, en_apin;
    logic [7:0]  hold_cycles;
    logic        ready, rd_valid;
    logic [15:0] rd_data;
    logic        wr_req, rd_req, pd_req, sr_req, pass, complete;
    logic [5:0]  addr;
    logic [15:0] wr_data;
    logic [1:0]  byte_en, burst, pass_byte;
    logic [6:0]  status;

    always #2.5 clk = ~clk;

    memtest_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .en_short(en_short), .en_mask(en_mask),
        .en_apin(en_apin), .hold_cycles(hold_cycles), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .rd_req(rd_req),
        .addr(addr), .wr_data(wr_data), .byte_en(byte_en), .burst(burst),
        .pd_req(pd_req), .sr_req(sr_req), .pass(pass), .pass_byte(pass_byte),
        .status(status), .complete(complete)
    );

    typedef struct {int kind; int test; int addr; int data; int be; int burst;} op_t;
    typedef struct {int data; int exp; int due;} ret_t;
    op_t  plan[$];
    ret_t rq[$];
    int   mem [64];
    int   vectors = 0, fails = 0;
    int   cyc, outst, last_test, lp_cnt, rdnum, done_cnt, last_due;
    bit   prev_lp, m_pass, inject, finished = 0;
    bit [1:0] m_pnf;

    function automatic int pat(int a);
        logic [31:0] t;
        t = a * 40503;
        return int'(t[15:0] ^ 16'h5AC3);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic void add(int k, int t, int a, int d, int be, int b);
        op_t o;
        o.kind = k; o.test = t; o.addr = a; o.data = d; o.be = be; o.burst = b;
        plan.push_back(o);
    endfunction

    task automatic build(bit es, bit em, bit ea, int h);
        int al[$];
        int hh;
        hh = (h == 0) ? 1 : h;
        for (int a = 0; a < 16; a++) add(0, 0, a, pat(a), 3, 2);
        for (int a = 0; a < 16; a++) add(1, 0, a, pat(a), 3, 2);
        if (es) begin
            for (int a = 0; a < 16; a++) add(0, 1, a, (~pat(a)) & 16'hFFFF, 3, 1);
            for (int a = 0; a < 16; a++) add(1, 1, a, (~pat(a)) & 16'hFFFF, 3, 1);
        end
        if (em) begin
            for (int a = 0; a < 16; a++) add(0, 2, a, 0, 3, 2);
            for (int a = 0; a < 16; a++) add(0, 2, a, 16'hFFFF, 1, 2);
            for (int a = 0; a < 16; a++) add(1, 2, a, 16'h00FF, 3, 2);
        end
        if (ea) begin
            al.push_back(0);
            for (int b = 0; b < 6; b++) al.push_back(1 << b);
            for (int b = 0; b < 6; b++) al.push_back(63 & ~(1 << b));
            al.push_back(0);
            foreach (al[i]) begin
                add(0, 3, al[i], pat(al[i]) ^ 16'h3C3C, 3, 2);
                add(1, 3, al[i], pat(al[i]) ^ 16'h3C3C, 3, 2);
            end
        end
        add(2, 4, 0, hh, 0, 0);
        add(2, 5, 0, hh, 0, 0);
    endtask

    task automatic step();
        op_t  o;
        ret_t r;
        int   d;
        bit   lp;
        // per-clock comparison against the model
        check(pass == m_pass, "R1 pass", pass, m_pass);
        check(pass_byte == m_pnf, "R2 pass_byte", pass_byte, m_pnf);
        check(status[6] == 1'b0 && $countones(status) <= 1, "R3 status shape", status, 0);
        if (complete) begin
            done_cnt++;
            check(plan.size() == 0 && outst == 0, "R4 complete early", plan.size(), 0);
        end else if (done_cnt > 0) begin
            check(!(wr_req || rd_req || pd_req || sr_req), "R4 activity after end",
                  {wr_req, rd_req, pd_req, sr_req}, 0);
        end
        // ready pattern with gaps
        ready = ((cyc % 7) != 3) && ((cyc % 11) != 5);
        // low-power holds
        lp = pd_req || sr_req;
        if (lp) begin
            lp_cnt++;
            check(!(wr_req || rd_req) && !(pd_req && sr_req), "R10 quiet hold",
                  {wr_req, rd_req, pd_req, sr_req}, 0);
            check(status == (pd_req ? 7'h10 : 7'h20), "R3 hold status", status,
                  pd_req ? 7'h10 : 7'h20);
        end
        if (prev_lp && !lp) begin
            if (plan.size() == 0) check(0, "R11 extra hold", lp_cnt, 0);
            else begin
                o = plan.pop_front();
                check(o.kind == 2, "R10 hold order", o.kind, 2);
                check(lp_cnt == o.data, "R10 hold length", lp_cnt, o.data);
            end
            lp_cnt = 0;
        end
        if (!prev_lp && lp && plan.size() > 0) begin
            check(plan[0].kind == 2 && plan[0].test == (pd_req ? 4 : 5), "R10 hold kind",
                  pd_req ? 4 : 5, plan[0].test);
        end
        prev_lp = lp;
        // request handoff
        if ((wr_req || rd_req) && ready) begin
            if (plan.size() == 0) begin
                check(0, "R11 unexpected request", addr, 0);
            end else begin
                o = plan.pop_front();
                if (o.test != last_test) begin
                    check(outst == 0, "R12 drain before next test", outst, 0);
                    last_test = o.test;
                end
                check(rd_req == (o.kind == 1), "R11 request kind", rd_req, o.kind);
                check(addr == o.addr[5:0], o.test == 3 ? "R9 address" : "R6 address", addr, o.addr);
                check(status == 7'(1 << o.test), "R3 status", status, 1 << o.test);
                check(burst == o.burst[1:0], o.test == 1 ? "R7 burst" : "R6 burst", burst, o.burst);
                if (wr_req) begin
                    check(wr_data == o.data[15:0], "R8 write data", wr_data, o.data);
                    check(byte_en == o.be[1:0], "R8 byte enable", byte_en, o.be);
                end
            end
            if (wr_req) begin
                if (byte_en[0]) mem[addr][7:0]  = int'(wr_data[7:0]);
                if (byte_en[1]) mem[addr][15:8] = int'(wr_data[15:8]);
            end else begin
                rdnum++;
                d = mem[addr] & 16'hFFFF;
                if (inject && rdnum == 3) d = d ^ 16'h0200;
                if (inject && rdnum == 5) d = d ^ 16'h0004;
                r.data = d;
                r.exp  = (plan.size() >= 0 && o.kind == 1) ? o.data : d;
                r.due  = (cyc + 1 + (rdnum % 3) > last_due + 1) ? cyc + 1 + (rdnum % 3) : last_due + 1;
                last_due = r.due;
                rq.push_back(r);
                outst++;
            end
        end
        // read return
        if (rq.size() > 0 && rq[0].due <= cyc) begin
            r = rq.pop_front();
            rd_valid = 1'b1;
            rd_data  = r.data[15:0];
            m_pnf[0] = (r.data & 16'h00FF) == (r.exp & 16'h00FF);
            m_pnf[1] = (r.data & 16'hFF00) == (r.exp & 16'hFF00);
            if ((r.data & 16'hFFFF) != (r.exp & 16'hFFFF)) m_pass = 1'b0;
            outst--;
        end else begin
            rd_valid = 1'b0;
            rd_data  = 16'hDEAD;
        end
    endtask

    task automatic run(bit es, bit em, bit ea, int h, bit inj);
        int guard;
        int post;
        rst_n = 1'b0;
        en_short = es; en_mask = em; en_apin = ea;
        hold_cycles = 8'(h);
        ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
        plan.delete(); rq.delete();
        for (int i = 0; i < 64; i++) mem[i] = (i * 37 + 11) & 16'hFFFF;
        cyc = 0; outst = 0; last_test = -1; lp_cnt = 0; rdnum = 0; done_cnt = 0;
        last_due = 0; prev_lp = 0; m_pass = 1; m_pnf = 2'b11; inject = inj;
        build(es, em, ea, h);
        repeat (3) @(negedge clk);
        check(pass == 1'b1, "R1 reset pass", pass, 1);
        check(pass_byte == 2'b11, "R2 reset lanes", pass_byte, 3);
        check(status == 7'd0, "R3 reset status", status, 0);
        check(complete == 1'b0, "R4 reset complete", complete, 0);
        check(!wr_req && !rd_req, "R5 reset request", {wr_req, rd_req}, 0);
        rst_n = 1'b1;
        guard = 0;
        post = 0;
        while (post < 20 && guard < 5000) begin
            @(negedge clk);
            cyc++;
            step();
            guard++;
            if (done_cnt > 0) post++;
        end
        if (guard >= 5000) check(0, "watchdog R4", guard, 0);
        check(done_cnt == 1, "R4 single pulse", done_cnt, 1);
        check(plan.size() == 0, "R11 all steps seen", plan.size(), 0);
        check(pass == !inj, "R1 final pass", pass, !inj);
    endtask

    initial begin
        run(1, 1, 1, 5, 0);
        run(0, 1, 0, 0, 1);
        run(0, 0, 1, 2, 0);
        run(1, 0, 0, 1, 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            vectors++;
            $display("FAIL watchdog R4 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule